// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block sits next to the refill path of a first-level cache and holds lines it has fetched ahead of demand. It has one or more ways. Each way is a short queue of line slots together with a running "next line" pointer. When the cache misses, the miss line address is compared with the oldest entry of every way at the same time. If one of them matches and its data has arrived, that line goes back to the cache one cycle later. The entry leaves its queue, and the freed slot lets the way fetch one more consecutive line.

If no way matches, the block answers "not held" one cycle later and gives the least-recently-used way to a new stream. That way drops its contents and starts fetching at the line after the miss. Prefetched lines never go into the cache on their own. They wait in the queue until the cache asks for exactly the oldest one.

Requests go to a pipelined next-level memory port, so many of them can be in flight. The memory returns one response per request, in order. An in-order tracker remembers which way and slot each request belongs to. When a way is reassigned, the tracker marks that way's pending responses as dead, so the old data is dropped on arrival.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset no response is presented (`resp_valid`=0), no request is raised (`mem_req_valid`=0), no way is streaming, and `miss_ready`=1.
- R2: Only the oldest entry of each way is compared. A miss whose line sits deeper in a queue gets a "not held" response and causes a reassignment, exactly as an unknown line does.
- R3: When a miss is accepted and it matches the oldest entry of a way whose data has arrived, the next cycle shows `resp_valid`=1, `resp_hit`=1 and that line's data. The entry then leaves its queue.
- R4: When an accepted miss matches an oldest entry whose data is still outstanding:
  - `miss_ready` drops the next cycle and no "not held" response is given.
  - The hit response with the data appears in the cycle after the one in which the data was stored.
  - `miss_ready` returns to 1 in that same cycle.
- R5: When an accepted miss matches no oldest entry:
  - The next cycle shows `resp_valid`=1, `resp_hit`=0 and `resp_data`=0.
  - The chosen way is emptied and restarts with `miss_line`+1 as its first request.
- R6: Each cycle the request port offers the next line of the lowest-numbered way that is streaming and has a free slot. A way's lines are requested in increasing consecutive order. A way never has more than DEPTH slots allocated (pending plus held). No request is raised while TRK_DEPTH requests are in flight.
- R7: Memory responses are matched to requests in order, one per request. A response to a request issued by a way that has since been reassigned is dropped.
- R8: The way reassigned on a miss is the least-recently-used way. A way counts as used when an accepted miss hits it or reassigns it. After reset, way 0 counts as most recent and way NWAYS-1 as least recent.
- R9: The oldest entries of all ways are compared with the miss in parallel. A match in any way is a hit, and the lowest-numbered matching way wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Cache miss presented |
| miss_line | input | ADDR_W | Line address of the miss |
| miss_ready | output | 1 | Block can accept a miss this cycle |
| resp_valid | output | 1 | Response to an accepted miss |
| resp_hit | output | 1 | 1: line supplied from the buffer; 0: not held |
| resp_data | output | DATA_W | Line data on a hit, zero otherwise |
| mem_req_valid | output | 1 | Prefetch request to next level |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_line | output | ADDR_W | Line address requested |
| mem_rsp_valid | input | 1 | In-order response from next level |
| mem_rsp_data | input | DATA_W | Response line data |

## Verification
A wrong way pointer, slot tag or tracker entry shows up at the ports within a cycle or two:
- a wrong `mem_req_line`;
- a request raised or withheld against the slot budget;
- hit data that belongs to another line;
- a "not held" answer where a hit was due.

A stale response written into a reassigned way hides until that slot becomes the oldest and is hit, so those paths are exercised by thrashing more streams than there are ways. A wrong recency order only appears as hit-versus-miss differences over several misses, which is why the bench compares every output on every clock against a behavioural model.

// File: rtl/spb_pkg.sv
package spb_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_WAIT = 1'b1
  } spb_state_e;
endpackage

// File: rtl/spb_way.sv
// One prefetch stream: a circular queue of line slots and its next-line pointer.
module spb_way #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [ADDR_W-1:0] start_line,
  input  logic              alloc,
  input  logic              pop,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] probe_line,
  output logic              head_match,
  output logic              head_ready,
  output logic [DATA_W-1:0] head_data,
  output logic              want_req,
  output logic [ADDR_W-1:0] req_line,
  output logic [SLOT_W-1:0] tail_slot
);

  logic              streaming;
  logic [ADDR_W-1:0] next_line;
  logic [SLOT_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  fill;
  logic [ADDR_W-1:0] tag_q   [DEPTH];
  logic [DEPTH-1:0]  have_q;
  logic [DATA_W-1:0] line_mem [DEPTH];

  function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      streaming <= 1'b0;
      next_line <= '0;
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      fill      <= '0;
    end else if (flush) begin
      streaming <= 1'b1;
      next_line <= start_line;
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      fill      <= '0;
    end else begin
      if (alloc) begin
        wr_ptr    <= bump(wr_ptr);
        next_line <= next_line + 1'b1;
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      fill <= fill + CNT_W'(alloc) - CNT_W'(pop);
    end
  end

  // Tag storage: written when a slot is claimed for a request.
  always_ff @(posedge clk) begin
    if (alloc && !flush) tag_q[wr_ptr] <= next_line;
  end

  // Arrival flags: set by a returning response, cleared on claim.
  always_ff @(posedge clk) begin
    if (rst) begin
      have_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && wr_slot == SLOT_W'(i)) have_q[i] <= 1'b1;
        if (alloc && !flush && wr_ptr == SLOT_W'(i)) have_q[i] <= 1'b0;
      end
    end
  end

  // Line data: simple dual-port storage, no reset.
  always_ff @(posedge clk) begin
    if (wr_en) line_mem[wr_slot] <= wr_data;
  end

  assign head_match = streaming && (fill != '0) && (tag_q[rd_ptr] == probe_line);
  assign head_ready = have_q[rd_ptr];
  assign head_data  = line_mem[rd_ptr];
  assign want_req   = streaming && (fill < CNT_W'(DEPTH));
  assign req_line   = next_line;
  assign tail_slot  = wr_ptr;

endmodule

// File: rtl/spb_lru.sv
// Recency ages per way: 0 is most recent, NWAYS-1 is the replacement victim.
module spb_lru #(
  parameter int NWAYS = 2,
  localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim
);

  logic [WAY_W-1:0] age_q [NWAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NWAYS; w++) age_q[w] <= WAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < NWAYS; w++) begin
        if (WAY_W'(w) == touch_way) age_q[w] <= '0;
        else if (age_q[w] < age_q[touch_way]) age_q[w] <= age_q[w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (age_q[w] == WAY_W'(NWAYS - 1)) victim = WAY_W'(w);
    end
  end

endmodule

// File: rtl/spb_track.sv
// In-order record of outstanding requests: owner way, slot, and a live flag.
module spb_track #(
  parameter int NWAYS     = 2,
  parameter int DEPTH     = 4,
  parameter int TRK_DEPTH = 8,
  localparam int WAY_W  = (NWAYS > 1) ? $clog2(NWAYS) : 1,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PTR_W  = (TRK_DEPTH > 1) ? $clog2(TRK_DEPTH) : 1,
  localparam int TCNT_W = $clog2(TRK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [WAY_W-1:0]  push_way,
  input  logic [SLOT_W-1:0] push_slot,
  input  logic              push_live,
  input  logic              kill,
  input  logic [WAY_W-1:0]  kill_way,
  input  logic              pop,
  output logic [WAY_W-1:0]  head_way,
  output logic [SLOT_W-1:0] head_slot,
  output logic              head_live,
  output logic              full,
  output logic [TCNT_W-1:0] count
);

  logic [WAY_W-1:0]     way_q  [TRK_DEPTH];
  logic [SLOT_W-1:0]    slot_q [TRK_DEPTH];
  logic [TRK_DEPTH-1:0] live_q;
  logic [PTR_W-1:0]     rd_ptr, wr_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(TRK_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + TCNT_W'(push) - TCNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      way_q[wr_ptr]  <= push_way;
      slot_q[wr_ptr] <= push_slot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
    end else begin
      for (int i = 0; i < TRK_DEPTH; i++) begin
        if (kill && way_q[i] == kill_way) live_q[i] <= 1'b0;
        if (push && wr_ptr == PTR_W'(i))  live_q[i] <= push_live;
      end
    end
  end

  assign head_way  = way_q[rd_ptr];
  assign head_slot = slot_q[rd_ptr];
  assign head_live = live_q[rd_ptr];
  assign full      = (count == TCNT_W'(TRK_DEPTH));

endmodule

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf
  import spb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int NWAYS     = 2,
  parameter int DEPTH     = 4,
  parameter int TRK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_line,
  output logic              miss_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_line,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  localparam int WAY_W  = (NWAYS > 1) ? $clog2(NWAYS) : 1;
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TCNT_W = $clog2(TRK_DEPTH + 1);

  logic [NWAYS-1:0]  way_match, way_ready, way_want;
  logic [NWAYS-1:0]  way_flush, way_alloc, way_pop, way_wr;
  logic [DATA_W-1:0] way_data [NWAYS];
  logic [ADDR_W-1:0] way_req_line [NWAYS];
  logic [SLOT_W-1:0] way_tail [NWAYS];

  spb_state_e        state_q;
  logic [WAY_W-1:0]  wait_way_q;

  logic              hit_any, grant_any;
  logic [WAY_W-1:0]  hit_way, grant_way, victim;
  logic              accept, refill, hit_now, hit_park, wait_done, fire;

  logic [WAY_W-1:0]  trk_head_way;
  logic [SLOT_W-1:0] trk_head_slot;
  logic              trk_head_live, trk_full;
  logic [TCNT_W-1:0] trk_cnt;

  // Parallel head compare and request arbitration, lowest way first.
  always_comb begin
    hit_any   = 1'b0;
    hit_way   = '0;
    grant_any = 1'b0;
    grant_way = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (way_match[w] && !hit_any) begin
        hit_any = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (way_want[w] && !grant_any) begin
        grant_any = 1'b1;
        grant_way = WAY_W'(w);
      end
    end
  end

  assign miss_ready    = (state_q == ST_RUN);
  assign accept        = miss_valid && miss_ready;
  assign refill        = accept && !hit_any;
  assign hit_now       = accept && hit_any && way_ready[hit_way];
  assign hit_park      = accept && hit_any && !way_ready[hit_way];
  assign wait_done     = (state_q == ST_WAIT) && way_ready[wait_way_q];
  assign mem_req_valid = grant_any && !trk_full;
  assign mem_req_line  = way_req_line[grant_way];
  assign fire          = mem_req_valid && mem_req_ready;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    assign way_flush[w] = refill && (victim == WAY_W'(w));
    assign way_alloc[w] = fire && (grant_way == WAY_W'(w)) && !way_flush[w];
    assign way_pop[w]   = (hit_now && hit_way == WAY_W'(w)) ||
                          (wait_done && wait_way_q == WAY_W'(w));
    assign way_wr[w]    = mem_rsp_valid && trk_head_live && (trk_head_way == WAY_W'(w));

    spb_way #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
    ) u_way (
      .clk        (clk),
      .rst        (rst),
      .flush      (way_flush[w]),
      .start_line (miss_line + 1'b1),
      .alloc      (way_alloc[w]),
      .pop        (way_pop[w]),
      .wr_en      (way_wr[w]),
      .wr_slot    (trk_head_slot),
      .wr_data    (mem_rsp_data),
      .probe_line (miss_line),
      .head_match (way_match[w]),
      .head_ready (way_ready[w]),
      .head_data  (way_data[w]),
      .want_req   (way_want[w]),
      .req_line   (way_req_line[w]),
      .tail_slot  (way_tail[w])
    );
  end

  spb_track #(
    .NWAYS     (NWAYS),
    .DEPTH     (DEPTH),
    .TRK_DEPTH (TRK_DEPTH)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .push      (fire),
    .push_way  (grant_way),
    .push_slot (way_tail[grant_way]),
    .push_live (!(refill && victim == grant_way)),
    .kill      (refill),
    .kill_way  (victim),
    .pop       (mem_rsp_valid),
    .head_way  (trk_head_way),
    .head_slot (trk_head_slot),
    .head_live (trk_head_live),
    .full      (trk_full),
    .count     (trk_cnt)
  );

  spb_lru #(
    .NWAYS (NWAYS)
  ) u_lru (
    .clk       (clk),
    .rst       (rst),
    .touch     (accept),
    .touch_way (hit_any ? hit_way : victim),
    .victim    (victim)
  );

  // Registered response path and wait state.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      wait_way_q <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (hit_now) begin
        resp_valid <= 1'b1;
        resp_hit   <= 1'b1;
        resp_data  <= way_data[hit_way];
      end else if (hit_park) begin
        state_q    <= ST_WAIT;
        wait_way_q <= hit_way;
      end else if (refill) begin
        resp_valid <= 1'b1;
        resp_hit   <= 1'b0;
        resp_data  <= '0;
      end
      if (wait_done) begin
        state_q    <= ST_RUN;
        resp_valid <= 1'b1;
        resp_hit   <= 1'b1;
        resp_data  <= way_data[wait_way_q];
      end
    end
  end

endmodule

// File: rtl/stream_prefetch_buf_chk.sv
module stream_prefetch_buf_chk #(
  parameter int TRK_DEPTH = 8,
  localparam int TCNT_W = $clog2(TRK_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              mem_req_valid,
  input logic              mem_rsp_valid,
  input logic [TCNT_W-1:0] trk_cnt
);

  // R3: an accepted miss is answered next cycle unless the block parks in wait.
  p_answer_or_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready) |=> (resp_valid || !miss_ready));

  // R3: a response always follows an accepted miss or a wait.
  p_resp_has_cause_r3: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ($past(miss_valid && miss_ready) || $past(!miss_ready)));

  // R4: entering the wait gives no response.
  p_wait_entry_silent_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(miss_ready) |-> !resp_valid);

  // R4: leaving the wait always delivers a hit.
  p_wait_exit_hit_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(miss_ready) |-> (resp_valid && resp_hit));

  // R6: no request is offered while the in-flight record is full.
  p_no_overissue_r6: assert property (@(posedge clk) disable iff (rst)
    (trk_cnt == TCNT_W'(TRK_DEPTH)) |-> !mem_req_valid);

  // R7: every memory response pairs with a recorded request.
  p_rsp_paired_r7: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |-> (trk_cnt != '0));

endmodule

bind stream_prefetch_buf stream_prefetch_buf_chk #(
  .TRK_DEPTH (TRK_DEPTH)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .miss_valid    (miss_valid),
  .miss_ready    (miss_ready),
  .resp_valid    (resp_valid),
  .resp_hit      (resp_hit),
  .mem_req_valid (mem_req_valid),
  .mem_rsp_valid (mem_rsp_valid),
  .trk_cnt       (trk_cnt)
);

// File: tb/stream_prefetch_buf_bench.sv
module stream_prefetch_buf_bench;
  localparam int NW = 2, DEP = 4, TRK = 8, AW = 16, DW = 32, LAT = 5, NCYC = 4000;

  logic          clk = 1'b0;
  logic          rst;
  logic          miss_valid, miss_ready, resp_valid, resp_hit;
  logic [AW-1:0] miss_line, mem_req_line;
  logic [DW-1:0] resp_data, mem_rsp_data;
  logic          mem_req_valid, mem_req_ready, mem_rsp_valid;

  always #10 clk = ~clk;  // 50 MHz

  stream_prefetch_buf #(
    .ADDR_W(AW), .DATA_W(DW), .NWAYS(NW), .DEPTH(DEP), .TRK_DEPTH(TRK)
  ) u_stream_prefetch_buf (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_line(miss_line),
    .miss_ready(miss_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_data(resp_data), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_line(mem_req_line), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mdata(input int line);
    return (DW'(line) * 32'h9E3779B1) ^ 32'h00005A5A;
  endfunction

  bit [31:0] rs = 32'h1234_5678;
  function automatic int rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return int'(rs & 32'h7FFF_FFFF);
  endfunction

  // Behavioural reference model
  typedef struct { int line; bit avail; logic [DW-1:0] data; } ent_t;
  ent_t  wq [NW][$];
  int    trk_w[$], trk_g[$], lru[$];
  int    pend_due[$];
  logic [DW-1:0] pend_dat[$];
  bit    m_active[NW], m_fresh[NW];
  int    m_next[NW], m_gen[NW];
  bit    m_stall, m_rv, m_rh;
  int    m_sw;
  logic [DW-1:0] m_rd;
  string m_tag;
  int    c_hit = 0, c_hit_up = 0, c_stall = 0, c_flush = 0, c_drop = 0, c_deep = 0, c_req = 0;

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int a_ptr, s0, s1, rr, gap, toggle;
    int s3[3];
    rst = 1; miss_valid = 0; miss_line = '0; mem_req_ready = 0;
    mem_rsp_valid = 0; mem_rsp_data = '0;
    for (int w = 0; w < NW; w++) begin
      m_active[w] = 0; m_fresh[w] = 0; m_next[w] = 0; m_gen[w] = 0;
      lru.push_back(w);
    end
    m_stall = 0; m_rv = 0; m_rh = 0; m_rd = '0; m_sw = 0; m_tag = "R3";
    a_ptr = 16'h0100; s0 = 16'h0500; s1 = 16'h0900;
    s3[0] = 16'h1000; s3[1] = 16'h2000; s3[2] = 16'h3000;
    rr = 0; gap = 0; toggle = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1: reset state
    check(resp_valid == 1'b0, "R1", "resp_valid", resp_valid, 0);
    check(mem_req_valid == 1'b0, "R1", "mem_req_valid", mem_req_valid, 0);
    check(miss_ready == 1'b1, "R1", "miss_ready", miss_ready, 1);

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      int gw, hw, vic, popw, flushw, ph;
      bit pv, mv, rdy, rspv, acc, sdone, n_stall, n_rv, n_rh, fire;
      int n_sw, ml;
      logic [DW-1:0] n_rd, rspd;
      string n_tag;
      // outputs predicted from present model state
      pv = 0; gw = 0;
      if (trk_w.size() < TRK)
        for (int w = 0; w < NW; w++)
          if (m_active[w] && wq[w].size() < DEP) begin pv = 1; gw = w; break; end
      check(miss_ready == !m_stall, "R4", "miss_ready", miss_ready, !m_stall);
      check(resp_valid == m_rv, m_rv ? m_tag : "R3", "resp_valid", resp_valid, m_rv);
      if (m_rv) begin
        check(resp_hit == m_rh, m_tag, "resp_hit", resp_hit, m_rh);
        check(resp_data == m_rd, m_tag, "resp_data", resp_data, m_rd);
      end
      check(mem_req_valid == pv, "R6", "mem_req_valid", mem_req_valid, pv);
      if (pv) begin
        c_req++;
        check(mem_req_line == AW'(m_next[gw]), m_fresh[gw] ? "R5" : "R6",
              "mem_req_line", mem_req_line, m_next[gw]);
      end

      // stimulus for the next edge
      ph = cyc / 1000;
      rdy = (ph == 0) ? 1'b1 : ((rnd() % 4) != 0);
      rspv = 0; rspd = '0;
      if (pend_due.size() > 0 && pend_due[0] <= cyc) begin
        rspv = 1; rspd = pend_dat[0];
        void'(pend_due.pop_front()); void'(pend_dat.pop_front());
      end
      mv = 0; ml = 0;
      if (!m_stall && gap == 0) begin
        mv = 1;
        case (ph)
          0: begin
            if (rnd() % 40 == 0) a_ptr += 50;
            ml = a_ptr; a_ptr++; gap = rnd() % 8;
          end
          1: begin
            if (toggle) begin ml = s1; s1++; end else begin ml = s0; s0++; end
            toggle ^= 1; gap = rnd() % 4;
          end
          2: begin
            ml = s3[rr]; s3[rr]++; rr = (rr + 1) % 3; gap = rnd() % 3;
          end
          default: begin
            int r;
            r = rnd() % 8;
            if (r == 0) ml = a_ptr + 2;
            else if (r == 1) ml = 16'h4000 + (rnd() % 16'h3000);
            else ml = a_ptr;
            a_ptr = ml + 1; gap = rnd() % 3;
          end
        endcase
      end else if (gap > 0) begin
        gap--;
      end
      fire = pv && rdy;
      if (fire) begin
        pend_due.push_back(cyc + LAT);
        pend_dat.push_back(mdata(m_next[gw]));
      end

      // model step: decisions on present state
      acc = mv && !m_stall;
      hw = -1;
      if (acc)
        for (int w = 0; w < NW; w++)
          if (m_active[w] && wq[w].size() > 0 && wq[w][0].line == ml) begin hw = w; break; end
      sdone = m_stall && wq[m_sw].size() > 0 && wq[m_sw][0].avail;
      vic = lru[NW-1];
      popw = -1; flushw = -1;
      n_stall = m_stall; n_sw = m_sw; n_rv = 0; n_rh = m_rh; n_rd = m_rd; n_tag = m_tag;
      if (acc) begin
        if (hw >= 0) begin
          if (wq[hw][0].avail) begin
            n_rv = 1; n_rh = 1; n_rd = wq[hw][0].data; popw = hw; c_hit++;
            if (hw != 0) c_hit_up++;
            n_tag = (hw != 0) ? "R3 R7 R9" : "R3 R7";
          end else begin
            n_stall = 1; n_sw = hw; c_stall++;
          end
        end else begin
          bit deep;
          deep = 0;
          for (int w = 0; w < NW; w++)
            for (int i = 1; i < wq[w].size(); i++)
              if (wq[w][i].line == ml) deep = 1;
          if (deep) c_deep++;
          n_rv = 1; n_rh = 0; n_rd = '0; flushw = vic; c_flush++;
          n_tag = deep ? "R2 R5 R8" : "R5 R8";
        end
      end
      if (sdone) begin
        n_rv = 1; n_rh = 1; n_rd = wq[m_sw][0].data; popw = m_sw; n_stall = 0;
        n_tag = "R4 R7";
      end
      if (rspv) begin
        int w, g;
        w = trk_w.pop_front(); g = trk_g.pop_front();
        if (g == m_gen[w]) begin
          for (int i = 0; i < wq[w].size(); i++)
            if (!wq[w][i].avail) begin wq[w][i].avail = 1; wq[w][i].data = rspd; break; end
        end else c_drop++;
      end
      if (fire) begin
        ent_t e;
        e.line = m_next[gw]; e.avail = 0; e.data = '0;
        wq[gw].push_back(e);
        trk_w.push_back(gw); trk_g.push_back(m_gen[gw]);
        m_next[gw]++; m_fresh[gw] = 0;
      end
      if (popw >= 0) void'(wq[popw].pop_front());
      if (flushw >= 0) begin
        m_gen[flushw]++; wq[flushw].delete(); m_active[flushw] = 1;
        m_next[flushw] = ml + 1; m_fresh[flushw] = 1;
      end
      if (acc) begin
        int tw;
        tw = (hw >= 0) ? hw : vic;
        for (int i = 0; i < lru.size(); i++) if (lru[i] == tw) begin lru.delete(i); break; end
        lru.push_front(tw);
      end
      m_stall = n_stall; m_sw = n_sw; m_rv = n_rv; m_rh = n_rh; m_rd = n_rd; m_tag = n_tag;

      miss_valid = mv; miss_line = AW'(ml); mem_req_ready = rdy;
      mem_rsp_valid = rspv; mem_rsp_data = rspd;
      @(negedge clk);
    end

    // stimulus reached every behaviour the requirements name
    check(c_hit > 0, "R3", "hits with data present", c_hit, 1);
    check(c_stall > 0, "R4", "hits waiting for data", c_stall, 1);
    check(c_flush > 0, "R5", "restarts", c_flush, 1);
    check(c_deep > 0, "R2", "deep-entry misses", c_deep, 1);
    check(c_drop > 0, "R7", "dropped stale responses", c_drop, 1);
    check(c_hit_up > 0, "R9", "hits in a higher way", c_hit_up, 1);
    check(c_req > 0, "R6", "requests issued", c_req, 1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule